// File: doc/BRIEF.md
# Fully Associative Read Cache with First-In-First-Out Replacement

This block is a small read-only cache that sits between a byte-addressed requester and a slower block memory. Each access carries a 24-bit byte address. The upper 22 bits name a 4-byte memory block, and the lower 2 bits pick one byte inside that block. Any block may live in any line. On every request, the block number is compared against the stored tag of every line at once.

On a hit, the requested byte is returned in the same cycle as the request. On a miss, the block is fetched over a request/acknowledge port and written into a line. The byte is returned in the cycle the acknowledge arrives. The fill goes to an empty line while one remains. Once all lines are valid, the fill replaces the line that was loaded earliest. A pointer tracks that line, and it advances on every fill. Hits do not change which line is replaced next. The number of lines is a parameter.

Top module: `fa_fifo_cache`

## Requirements
- R1: After reset no line is valid: `cpu_ready_o` and `mem_req_o` are low, and the first request misses.
- R2: A request whose block is resident raises `cpu_ready_o` in the same cycle. `cpu_data_o` then holds byte `addr[1:0]` of the block, where byte 0 is bits 7:0 and byte 3 is bits 31:24.
- R3: A request that misses keeps `cpu_ready_o` low. From the next cycle `mem_req_o` is high with `mem_addr_o = cpu_addr_i[23:2]`, and both hold steady until `mem_ack_i`.
- R4: In the cycle `mem_ack_i` is high during a fetch, `cpu_ready_o` is high and `cpu_data_o` is the selected byte of `mem_data_i`. `mem_req_o` is low the next cycle, and later requests to that block hit.
- R5: While empty lines remain, a fill never displaces a valid line, so LINES distinct blocks loaded after reset are all resident together.
- R6: With all lines valid, a fill replaces the line loaded earliest, and every other block stays resident.
- R7: Hits do not change the replacement order. Successive evictions follow load order even when the oldest block was hit just before.
- R8: A block is never resident in more than one line, so a hit returns data from exactly one line.
- R9: With `cpu_req_i` low and no fetch pending, `cpu_ready_o` and `mem_req_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Read request, held until ready |
| cpu_addr_i | input | ADDR_W | Byte address, held with request |
| cpu_ready_o | output | 1 | Request completes this cycle |
| cpu_data_o | output | 8 | Returned byte |
| mem_req_o | output | 1 | Block fetch request |
| mem_addr_o | output | ADDR_W-2 | Block number to fetch |
| mem_ack_i | input | 1 | Fetch data valid, ends fetch |
| mem_data_i | input | 32 | Fetched block, byte 0 in bits 7:0 |

## Verification
A corrupted tag or valid bit shows up as a wrong hit/miss outcome on the very next request to that block. A wrong hit appears as an immediate ready with stale data, and a wrong miss appears as a spurious fetch on `mem_req_o` one cycle later. A replacement pointer that is off by one, or that moves on hits, stays hidden until the cache is full. It then shows up at the first eviction, when a block expected to be resident triggers a fetch and the block expected to be gone still hits. The bench therefore fills every line, runs hits against the oldest block, and then probes residency after each of two successive evictions.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_FETCH = 1'b1} fetch_state_e;
endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match #(
  parameter int LINES = 4,
  parameter int TAG_W = 22,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [TAG_W-1:0]              tag_i,
  input  logic [LINES-1:0]              valid_i,
  input  logic [LINES-1:0][TAG_W-1:0]   tags_i,
  output logic                          hit_o,
  output logic [IDX_W-1:0]              hit_idx_o
);
  logic [LINES-1:0] match;

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (tags_i[g] == tag_i);
  end

  // lowest-numbered line wins
  always_comb begin
    hit_idx_o = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |match;

  p_single_match_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(match) <= 1);
endmodule

// File: rtl/fa_victim_sel.sv
module fa_victim_sel #(
  parameter int LINES = 4,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] valid_i,
  input  logic             fill_i,
  output logic [IDX_W-1:0] victim_o
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign victim_o = any_free ? free_idx : ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (fill_i) ptr_q <= (ptr_q == IDX_W'(LINES - 1)) ? '0 : ptr_q + 1'b1;
  end

  p_ptr_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_i |=> $stable(ptr_q));
  p_empty_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i != '1) |-> !valid_i[victim_o]);
endmodule

// File: rtl/fa_line_store.sv
module fa_line_store #(
  parameter int LINES  = 4,
  parameter int TAG_W  = 22,
  parameter int DATA_W = 32,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic [IDX_W-1:0]              wr_idx_i,
  input  logic [TAG_W-1:0]              wr_tag_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic [IDX_W-1:0]              rd_idx_i,
  output logic [DATA_W-1:0]             rd_data_o,
  output logic [LINES-1:0]              valid_o,
  output logic [LINES-1:0][TAG_W-1:0]   tags_o
);
  logic [LINES-1:0][DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= '0;
    else if (wr_i) valid_o[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) begin
      tags_o[wr_idx_i] <= wr_tag_i;
      data_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_data_o = data_q[rd_idx_i];

  p_fill_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> valid_o[$past(wr_idx_i)] && (tags_o[$past(wr_idx_i)] == $past(wr_tag_i)));
endmodule

// File: rtl/fa_fifo_cache.sv
module fa_fifo_cache
  import fa_cache_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int ADDR_W = 24,
  localparam int OFF_W  = 2,
  localparam int TAG_W  = ADDR_W - OFF_W,
  localparam int BLK_W  = 8 << OFF_W,
  localparam int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic              cpu_ready_o,
  output logic [7:0]        cpu_data_o,
  output logic              mem_req_o,
  output logic [TAG_W-1:0]  mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [BLK_W-1:0]  mem_data_i
);
  fetch_state_e                state_q;
  logic [TAG_W-1:0]            tag;
  logic [OFF_W-1:0]            off;
  logic                        hit;
  logic [IDX_W-1:0]            hit_idx;
  logic [IDX_W-1:0]            victim;
  logic                        fill;
  logic [BLK_W-1:0]            line_data;
  logic [BLK_W-1:0]            sel_blk;
  logic [LINES-1:0]            valid;
  logic [LINES-1:0][TAG_W-1:0] tags;

  assign tag = cpu_addr_i[ADDR_W-1:OFF_W];
  assign off = cpu_addr_i[OFF_W-1:0];

  fa_tag_match #(.LINES(LINES), .TAG_W(TAG_W)) u_match (
    .clk_i, .rst_ni, .tag_i(tag), .valid_i(valid), .tags_i(tags),
    .hit_o(hit), .hit_idx_o(hit_idx)
  );

  fa_victim_sel #(.LINES(LINES)) u_victim (
    .clk_i, .rst_ni, .valid_i(valid), .fill_i(fill), .victim_o(victim)
  );

  fa_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(BLK_W)) u_store (
    .clk_i, .rst_ni, .wr_i(fill), .wr_idx_i(victim), .wr_tag_i(tag),
    .wr_data_i(mem_data_i), .rd_idx_i(hit_idx), .rd_data_o(line_data),
    .valid_o(valid), .tags_o(tags)
  );

  assign fill        = (state_q == ST_FETCH) && mem_ack_i;
  assign cpu_ready_o = cpu_req_i && (((state_q == ST_IDLE) && hit) || fill);
  assign sel_blk     = fill ? mem_data_i : line_data;
  assign cpu_data_o  = sel_blk[8*off +: 8];
  assign mem_req_o   = (state_q == ST_FETCH);
  assign mem_addr_o  = tag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else begin
      case (state_q)
        ST_IDLE:  if (cpu_req_i && !hit) state_q <= ST_FETCH;
        ST_FETCH: if (mem_ack_i) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));
  p_req_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> !mem_req_o);
  p_quiet_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_req_i |-> !cpu_ready_o);
  p_miss_fetch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_o && cpu_req_i && !cpu_ready_o |=> mem_req_o);
endmodule

// File: tb/fa_fifo_cache_tb.sv
module fa_fifo_cache_tb;
  localparam int LINES = 4;
  localparam int LAT   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic        cpu_ready;
  logic [7:0]  cpu_data;
  logic        mem_req;
  logic [21:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_data = '0;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  fa_fifo_cache #(.LINES(LINES)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(cpu_req), .cpu_addr_i(cpu_addr),
    .cpu_ready_o(cpu_ready), .cpu_data_o(cpu_data), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_ack_i(mem_ack), .mem_data_i(mem_data)
  );

  function automatic logic [31:0] blk(input logic [21:0] b);
    return {~b[7:0], b[7:0] ^ 8'h5A, b[15:8], b[7:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // starts and ends at a negedge
  task automatic access(input logic [21:0] b, input logic [1:0] off,
                        input bit exp_hit, input string req);
    logic [31:0] d = blk(b);
    cpu_req  = 1'b1;
    cpu_addr = {b, off};
    #1;
    check({req, " hit/miss"}, {31'd0, cpu_ready}, {31'd0, exp_hit});
    if (cpu_ready) begin
      check({req, " hit byte"}, {24'd0, cpu_data}, {24'd0, d[8*off +: 8]});
      @(negedge clk);
    end else begin
      @(negedge clk);
      check({req, " fetch req"}, {31'd0, mem_req}, 32'd1);
      check({req, " fetch addr"}, {10'd0, mem_addr}, {10'd0, b});
      for (int i = 0; i < LAT; i++) begin
        @(negedge clk);
        check({req, " ready low while fetching"}, {31'd0, cpu_ready}, 32'd0);
      end
      mem_ack  = 1'b1;
      mem_data = d;
      #1;
      check({req, " ready on ack"}, {31'd0, cpu_ready}, 32'd1);
      check({req, " fill byte"}, {24'd0, cpu_data}, {24'd0, d[8*off +: 8]});
      @(negedge clk);
      mem_ack = 1'b0;
      check({req, " fetch ends"}, {31'd0, mem_req}, 32'd0);
    end
    cpu_req = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 ready at reset", {31'd0, cpu_ready}, 32'd0);
    check("R1 mem_req at reset", {31'd0, mem_req}, 32'd0);
    access(22'h000A1, 2'd1, 1'b0, "R1 first access misses");
  endtask

  task automatic t_hit_bytes;
    for (int o = 0; o < 4; o++) access(22'h000A1, 2'(o), 1'b1, "R2 hit all offsets");
    access(22'h000A1, 2'd3, 1'b1, "R4 refilled block hits");
  endtask

  task automatic t_fill_empty;
    access(22'h000B2, 2'd0, 1'b0, "R5 fill 2");
    access(22'h000C3, 2'd2, 1'b0, "R5 fill 3");
    access(22'h3FFFF, 2'd3, 1'b0, "R5 fill 4");
    access(22'h000A1, 2'd0, 1'b1, "R5 first resident");
    access(22'h000B2, 2'd1, 1'b1, "R5 second resident");
    access(22'h000C3, 2'd2, 1'b1, "R5 third resident");
    access(22'h3FFFF, 2'd0, 1'b1, "R5 fourth resident");
  endtask

  task automatic t_fifo;
    access(22'h000A1, 2'd2, 1'b1, "R7 hit oldest");
    access(22'h000E5, 2'd1, 1'b0, "R6 evicting fill");
    access(22'h000B2, 2'd0, 1'b1, "R6 B kept");
    access(22'h000C3, 2'd0, 1'b1, "R6 C kept");
    access(22'h3FFFF, 2'd0, 1'b1, "R6 D kept");
    access(22'h000E5, 2'd2, 1'b1, "R6 E resident");
    access(22'h000A1, 2'd0, 1'b0, "R7 oldest evicted despite hit");
    access(22'h000B2, 2'd3, 1'b0, "R7 second eviction follows load order");
    access(22'h000A1, 2'd3, 1'b1, "R8 single copy returns right data");
    access(22'h000E5, 2'd3, 1'b1, "R8 E still resident");
  endtask

  task automatic t_idle;
    for (int i = 0; i < 5; i++) begin
      #1;
      check("R9 idle ready low", {31'd0, cpu_ready}, 32'd0);
      check("R9 idle no fetch", {31'd0, mem_req}, 32'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hit_bytes();
    t_fill_empty();
    t_fifo();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule